// File: doc/BRIEF.md
# Set/Clear/Toggle Control Register Bank

This block is the 32-bit control and status register file of a PHY. It keeps seven stored words and two constant words behind a word-addressed register bus. Six of the stored words are reached at four consecutive word addresses. The first address writes the word directly. The other three OR bits into it, clear bits in it, or flip bits in it, all in a single bus cycle. Software can therefore change one field without a read-modify-write sequence. Every stored word also drives an output port, so the surrounding PHY logic sees its settings at once.

The control word has a soft-reset bit, bit 31. Writing that bit reloads the power, transmit, receive and control words with their defaults. The status and debug words keep their values. The bus has plain strobes and no back-pressure: every access completes in the cycle in which its strobe is high. Read data and the error flag appear one cycle later. A read and a write may be issued in the same cycle. In that case the read returns the value from before the write.

Top module: `sct_regbank`

## Requirements
- R1: After the active-low asynchronous reset, the words hold these values: power 0x001E1C00, transmit 0x10060607, receive 0x00000000, control 0xC0200000, status 0x00000000, debug 0x7F180000, debug1 0x00001000. The constant words are version 0x04020000 and debug0-status 0x00000000.
- R2: The word index is `addr[11:2]`. A write to a base word replaces its value. The base words are at index 0 (power), 4 (transmit), 8 (receive), 12 (control), 16 (status), 20 (debug) and 28 (debug1). Words that are not addressed keep their values.
- R3: A write to base+1 ORs the write data into that base word.
- R4: A write to base+2 clears in the base word every bit that is 1 in the write data.
- R5: A write to base+3 XORs the write data into the base word.
- R6: A read returns data in the cycle after `rd_en`, and `rdata` holds its value between reads. A read of base+1, base+2 or base+3 returns the base word. Reads of index 16, 24 and 32 return status, debug0-status and version. A read of an unused index at or below 32 returns zero without an error.
- R7: A write to index 12 or 13 whose data has bit 31 set applies the write, then reloads power, transmit, receive and control with their R1 values. Status, debug and debug1 are left unchanged.
- R8: A write to index 15 with data bit 31 set triggers the reload only when control bit 31 is 1 after the XOR. Otherwise only the XOR takes effect. A write to index 14 never triggers the reload.
- R9: Writes to index 24, index 32, or any index without a writable word change nothing, and `err` is 1 in the following cycle.
- R10: A read of an index above 32 returns zero and sets `err` in the following cycle. Any access whose `addr[1:0]` is not 00 is rejected: it changes nothing, a read returns zero, and `err` is set. A legal access leaves `err` at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Write strobe for the current cycle |
| rd_en | input | 1 | Read strobe for the current cycle |
| addr | input | 12 | Byte address of the access |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data |
| err | output | 1 | Illegal access in the previous cycle |
| pwd_q | output | 32 | Power word |
| tx_q | output | 32 | Transmit word |
| rx_q | output | 32 | Receive word |
| ctrl_q | output | 32 | Control word, bit 31 is soft reset |
| status_q | output | 32 | Status word |
| debug_q | output | 32 | Debug word |
| debug1_q | output | 32 | Debug1 word |

## Verification
The assertions assume that `wr_en`, `rd_en`, `addr` and `wdata` are known and stable around each rising edge once reset is released. They also assume that `rst_n` is low at the start. The stimulus drives every input on the falling edge and issues one access at a time, separated by idle cycles. Each write-side property therefore sees exactly one decoded target. Reads sample the registered result on the next falling edge, well after the edge that produced it.

// File: rtl/sct_pkg.sv
package sct_pkg;
  localparam int DW       = 32;
  localparam int NSLOT    = 7;
  localparam int SLW      = $clog2(NSLOT);
  localparam int SRST_BIT = 31;

  // stored-word slots
  localparam int S_PWD  = 0;
  localparam int S_TX   = 1;
  localparam int S_RX   = 2;
  localparam int S_CTRL = 3;
  localparam int S_STAT = 4;
  localparam int S_DBG  = 5;
  localparam int S_DBG1 = 6;

  // word indices that are not alias groups
  localparam int W_STAT = 16;
  localparam int W_D0   = 24;
  localparam int W_VER  = 32;

  localparam logic [DW-1:0] VER_VAL = 32'h0402_0000;
  localparam logic [DW-1:0] D0_VAL  = 32'h0000_0000;

  typedef enum logic [2:0] {OP_NONE, OP_WR, OP_SET, OP_CLR, OP_TOG} op_e;
  typedef enum logic [1:0] {RS_SLOT, RS_VER, RS_D0, RS_ZERO} rsrc_e;

  function automatic logic [DW-1:0] slot_rst(int s);
    case (s)
      S_PWD:   return 32'h001E_1C00;
      S_TX:    return 32'h1006_0607;
      S_CTRL:  return 32'hC020_0000;
      S_DBG:   return 32'h7F18_0000;
      S_DBG1:  return 32'h0000_1000;
      default: return 32'h0000_0000;
    endcase
  endfunction

  // slots reloaded by the soft-reset bit
  function automatic bit slot_soft(int s);
    return (s <= S_CTRL);
  endfunction
endpackage

// File: rtl/sct_decode.sv
module sct_decode
  import sct_pkg::*;
#(
  parameter int AW = 12
) (
  input  logic [AW-1:0]    addr,
  input  logic             wr_en,
  input  logic             rd_en,
  output logic [NSLOT-1:0] wr_sel,
  output op_e              wr_op,
  output rsrc_e            rd_src,
  output logic [SLW-1:0]   rd_slot,
  output logic             acc_err
);
  localparam int WW = AW - 2;
  localparam int GW = WW - 2;

  logic [WW-1:0]  word;
  logic [GW-1:0]  grp;
  logic [1:0]     sub;
  logic           aligned, in_map, alias_hit, stat_hit, wr_ok;
  logic [SLW-1:0] aslot, tslot;
  op_e            aop;

  assign word    = addr[AW-1:2];
  assign grp     = word[WW-1:2];
  assign sub     = word[1:0];
  assign aligned = (addr[1:0] == 2'b00);
  assign in_map  = aligned && (word <= WW'(W_VER));

  // alias groups: four words per base
  always_comb begin
    alias_hit = 1'b1;
    aslot     = '0;
    case (grp)
      GW'(0):  aslot = SLW'(S_PWD);
      GW'(1):  aslot = SLW'(S_TX);
      GW'(2):  aslot = SLW'(S_RX);
      GW'(3):  aslot = SLW'(S_CTRL);
      GW'(5):  aslot = SLW'(S_DBG);
      GW'(7):  aslot = SLW'(S_DBG1);
      default: alias_hit = 1'b0;
    endcase
  end

  always_comb begin
    case (sub)
      2'd0:    aop = OP_WR;
      2'd1:    aop = OP_SET;
      2'd2:    aop = OP_CLR;
      default: aop = OP_TOG;
    endcase
  end

  assign stat_hit = (word == WW'(W_STAT));
  assign wr_ok    = aligned && (alias_hit || stat_hit);
  assign tslot    = stat_hit ? SLW'(S_STAT) : aslot;
  assign wr_sel   = (wr_en && wr_ok) ? (NSLOT'(1) << tslot) : '0;
  assign wr_op    = (wr_en && wr_ok) ? (stat_hit ? OP_WR : aop) : OP_NONE;
  assign rd_slot  = tslot;

  always_comb begin
    if (!in_map)                    rd_src = RS_ZERO;
    else if (alias_hit || stat_hit) rd_src = RS_SLOT;
    else if (word == WW'(W_VER))    rd_src = RS_VER;
    else if (word == WW'(W_D0))     rd_src = RS_D0;
    else                            rd_src = RS_ZERO;
  end

  assign acc_err = (wr_en && !wr_ok) || (rd_en && !in_map);
endmodule

// File: rtl/sct_field.sv
module sct_field
  import sct_pkg::*;
#(
  parameter logic [DW-1:0] RST_VAL = '0,
  parameter bit            SOFT    = 1'b0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sel,
  input  op_e           op,
  input  logic [DW-1:0] wdata,
  input  logic          srst,
  output logic [DW-1:0] q
);
  logic [DW-1:0] nxt;
  logic          reload;

  assign reload = SOFT && srst;

  always_comb begin
    case (op)
      OP_WR:   nxt = wdata;
      OP_SET:  nxt = q | wdata;
      OP_CLR:  nxt = q & ~wdata;
      OP_TOG:  nxt = q ^ wdata;
      default: nxt = q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      q <= RST_VAL;
    else if (reload) q <= RST_VAL;
    else if (sel)    q <= nxt;
  end

  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !sel && !reload |=> $stable(q));
  p_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
    sel && op == OP_WR && !reload |=> q == $past(wdata));
  p_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
    sel && op == OP_SET && !reload |=> (q & $past(wdata)) == $past(wdata));
  p_clr_r4: assert property (@(posedge clk) disable iff (!rst_n)
    sel && op == OP_CLR && !reload |=> (q & $past(wdata)) == '0);
  p_tog_r5: assert property (@(posedge clk) disable iff (!rst_n)
    sel && op == OP_TOG && !reload |=> q == ($past(q) ^ $past(wdata)));
  p_reload_r7: assert property (@(posedge clk) disable iff (!rst_n)
    reload |=> q == RST_VAL);
endmodule

// File: rtl/sct_regbank.sv
module sct_regbank
  import sct_pkg::*;
#(
  parameter int AW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic          rd_en,
  input  logic [AW-1:0] addr,
  input  logic [31:0]   wdata,
  output logic [31:0]   rdata,
  output logic          err,
  output logic [31:0]   pwd_q,
  output logic [31:0]   tx_q,
  output logic [31:0]   rx_q,
  output logic [31:0]   ctrl_q,
  output logic [31:0]   status_q,
  output logic [31:0]   debug_q,
  output logic [31:0]   debug1_q
);
  localparam int WW = AW - 2;

  logic [NSLOT-1:0] wr_sel;
  op_e              wr_op;
  rsrc_e            rd_src;
  logic [SLW-1:0]   rd_slot;
  logic             acc_err;
  logic             srst;
  logic [DW-1:0]    q_arr [NSLOT];
  logic [DW-1:0]    rd_val;

  sct_decode #(.AW(AW)) u_dec (
    .addr    (addr),
    .wr_en   (wr_en),
    .rd_en   (rd_en),
    .wr_sel  (wr_sel),
    .wr_op   (wr_op),
    .rd_src  (rd_src),
    .rd_slot (rd_slot),
    .acc_err (acc_err)
  );

  for (genvar i = 0; i < NSLOT; i++) begin : g_slot
    sct_field #(.RST_VAL(slot_rst(i)), .SOFT(slot_soft(i))) u_fld (
      .clk   (clk),
      .rst_n (rst_n),
      .sel   (wr_sel[i]),
      .op    (wr_op),
      .wdata (wdata),
      .srst  (srst),
      .q     (q_arr[i])
    );
  end

  // Soft reset: a direct or OR write with the bit set triggers it. An XOR
  // write triggers it only when the bit is 0 before and so 1 after.
  always_comb begin
    srst = 1'b0;
    if (wr_sel[S_CTRL] && wdata[SRST_BIT]) begin
      case (wr_op)
        OP_WR, OP_SET: srst = 1'b1;
        OP_TOG:        srst = !q_arr[S_CTRL][SRST_BIT];
        default:       srst = 1'b0;
      endcase
    end
  end

  always_comb begin
    case (rd_src)
      RS_SLOT: rd_val = q_arr[rd_slot];
      RS_VER:  rd_val = VER_VAL;
      RS_D0:   rd_val = D0_VAL;
      default: rd_val = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata <= '0;
      err   <= 1'b0;
    end else begin
      if (rd_en) rdata <= rd_val;
      err <= acc_err;
    end
  end

  assign pwd_q    = q_arr[S_PWD];
  assign tx_q     = q_arr[S_TX];
  assign rx_q     = q_arr[S_RX];
  assign ctrl_q   = q_arr[S_CTRL];
  assign status_q = q_arr[S_STAT];
  assign debug_q  = q_arr[S_DBG];
  assign debug1_q = q_arr[S_DBG1];

  p_ctrl_rd_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en && addr[1:0] == 2'b00 && addr[AW-1:4] == (AW-4)'(3) |=> rdata == $past(ctrl_q));
  p_srst_load_r7: assert property (@(posedge clk) disable iff (!rst_n)
    srst |=> pwd_q == 32'h001E_1C00 && tx_q == 32'h1006_0607 && rx_q == '0 && ctrl_q == 32'hC020_0000);
  p_srst_keep_r7: assert property (@(posedge clk) disable iff (!rst_n)
    srst |=> $stable(status_q) && $stable(debug_q) && $stable(debug1_q));
  p_clr_nosrst_r8: assert property (@(posedge clk) disable iff (!rst_n)
    wr_sel[S_CTRL] && wr_op == OP_CLR |-> !srst);
  p_tog_srst_r8: assert property (@(posedge clk) disable iff (!rst_n)
    wr_sel[S_CTRL] && wr_op == OP_TOG && wdata[SRST_BIT] && !ctrl_q[SRST_BIT]
    |=> ctrl_q == 32'hC020_0000 && pwd_q == 32'h001E_1C00);
  p_ro_err_r9: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && addr[1:0] == 2'b00 &&
    (addr[AW-1:2] == WW'(W_VER) || addr[AW-1:2] == WW'(W_D0)) |=> err);
  p_oob_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en && addr[AW-1:2] > WW'(W_VER) |=> err && rdata == '0);
  p_misalign_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en || rd_en) && addr[1:0] != 2'b00 |=> err);
endmodule

// File: tb/sct_regbank_bench.sv
`timescale 1ns/1ps
module sct_regbank_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [11:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata, pwd_q, tx_q, rx_q, ctrl_q, status_q, debug_q, debug1_q;
  logic        err;

  always #2.5 clk = ~clk;

  sct_regbank u_sct_regbank (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .err(err), .pwd_q(pwd_q), .tx_q(tx_q),
    .rx_q(rx_q), .ctrl_q(ctrl_q), .status_q(status_q), .debug_q(debug_q),
    .debug1_q(debug1_q)
  );

  int checks = 0;
  int fails  = 0;

  // scoreboard queues
  bit          sq_rd [$];
  logic [31:0] sq_val [$];
  bit          sq_err [$];
  string       sq_req [$];

  // spec model: one word per base index
  logic [31:0] mm [0:32];

  function automatic bit is_grp(int b);
    return b == 0 || b == 4 || b == 8 || b == 12 || b == 20 || b == 28;
  endfunction

  task automatic m_soft();
    mm[0] = 32'h001E_1C00; mm[4] = 32'h1006_0607;
    mm[8] = 32'h0; mm[12] = 32'hC020_0000;
  endtask

  task automatic m_init();
    for (int i = 0; i <= 32; i++) mm[i] = '0;
    mm[20] = 32'h7F18_0000; mm[28] = 32'h0000_1000; mm[32] = 32'h0402_0000;
    m_soft();
  endtask

  task automatic m_write(int a, logic [31:0] d, output bit e);
    int w = a >> 2;
    int b = w & ~3;
    int s = w - b;
    e = 1'b0;
    if (a % 4 != 0) e = 1'b1;
    else if (w < 32 && is_grp(b)) begin
      case (s)
        0: mm[b] = d;
        1: mm[b] = mm[b] | d;
        2: mm[b] = mm[b] & ~d;
        default: mm[b] = mm[b] ^ d;
      endcase
      if (b == 12 && d[31] && (s == 0 || s == 1 || (s == 3 && mm[12][31]))) m_soft();
    end else if (w == 16) mm[16] = d;
    else e = 1'b1;
  endtask

  task automatic m_read(int a, output logic [31:0] v, output bit e);
    int w = a >> 2;
    int b = w & ~3;
    e = (a % 4 != 0) || (w > 32);
    if (e) v = '0;
    else if (w < 32 && is_grp(b)) v = mm[b];
    else if (w == 16 || w == 24 || w == 32) v = mm[w];
    else v = '0;
  endtask

  // driver: called at a falling edge, returns at the next one
  task automatic acc(bit rd, int a, logic [31:0] d, string req);
    logic [31:0] v;
    bit e;
    if (rd) m_read(a, v, e);
    else begin m_write(a, d, e); v = '0; end
    rd_en = rd; wr_en = !rd; addr = 12'(a); wdata = d;
    sq_rd.push_back(rd); sq_val.push_back(v); sq_err.push_back(e); sq_req.push_back(req);
    @(negedge clk);
    wr_en = 1'b0; rd_en = 1'b0;
  endtask

  task automatic wr(int a, logic [31:0] d, string req); acc(1'b0, a, d, req); endtask
  task automatic rd(int a, string req); acc(1'b1, a, '0, req); endtask

  // monitor
  initial begin
    forever begin
      @(posedge clk);
      if (wr_en || rd_en) begin
        bit          r, e;
        logic [31:0] v;
        string       q;
        @(negedge clk);
        r = sq_rd.pop_front(); v = sq_val.pop_front();
        e = sq_err.pop_front(); q = sq_req.pop_front();
        checks++;
        if (err !== e || (r && rdata !== v)) begin
          fails++;
          $display("FAIL %s: rdata=%h err=%b expected rdata=%h err=%b", q, rdata, err, v, e);
        end
      end
    end
  end

  task automatic cmp(string req, string nm, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: %s=%h expected %h", req, nm, act, exp);
    end
  endtask

  task automatic chk_ports(string req);
    cmp(req, "pwd_q", pwd_q, mm[0]);    cmp(req, "tx_q", tx_q, mm[4]);
    cmp(req, "rx_q", rx_q, mm[8]);      cmp(req, "ctrl_q", ctrl_q, mm[12]);
    cmp(req, "status_q", status_q, mm[16]); cmp(req, "debug_q", debug_q, mm[20]);
    cmp(req, "debug1_q", debug1_q, mm[28]);
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    #1_000_000;
    checks++; fails++;
    $display("FAIL watchdog: run did not finish, expected completion");
    summary();
  end

  initial begin
    m_init();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state at the ports and through the bus
    chk_ports("R1");
    rd(12'h80, "R1"); rd(12'h60, "R1"); rd(12'h50, "R1"); rd(12'h70, "R1");
    // R2 direct writes
    wr(12'h00, 32'hA5A5_0001, "R2"); wr(12'h10, 32'h1234_5678, "R2");
    wr(12'h20, 32'h0F0F_0F0F, "R2"); wr(12'h40, 32'hDEAD_BEEF, "R2");
    wr(12'h50, 32'h0000_00FF, "R2"); wr(12'h70, 32'hFFFF_0000, "R2");
    rd(12'h00, "R2"); rd(12'h40, "R2");
    chk_ports("R2");
    // R3 set alias, read back through other aliases (R6)
    wr(12'h04, 32'h0000_00F0, "R3"); rd(12'h08, "R6");
    wr(12'h54, 32'hF000_0000, "R3"); rd(12'h5C, "R6");
    // R4 clear alias
    wr(12'h18, 32'h0000_FFFF, "R4"); rd(12'h14, "R6");
    wr(12'h78, 32'h0F00_0000, "R4"); rd(12'h70, "R4");
    // R5 toggle alias
    wr(12'h2C, 32'hFFFF_FFFF, "R5"); rd(12'h2C, "R6");
    wr(12'h7C, 32'h0000_1001, "R5"); rd(12'h74, "R5");
    // R6 holes read as zero, no error
    rd(12'h44, "R6"); rd(12'h68, "R6");
    chk_ports("R5");
    // R8 control without the soft bit, then clear alias never reloads
    wr(12'h30, 32'h0000_0003, "R8"); wr(12'h38, 32'h8000_0001, "R8");
    rd(12'h30, "R8");
    chk_ports("R8");
    // R8 toggle sets the bit: reload
    wr(12'h00, 32'h1111_1111, "R8"); wr(12'h3C, 32'h8000_0000, "R8");
    chk_ports("R8");
    // R8 toggle clears the bit: no reload
    wr(12'h10, 32'h2222_2222, "R8"); wr(12'h3C, 32'h8000_0000, "R8");
    rd(12'h3C, "R8");
    chk_ports("R8");
    // R7 set alias with the soft bit
    wr(12'h20, 32'h3333_3333, "R7"); wr(12'h34, 32'h8000_0000, "R7");
    chk_ports("R7");
    // R7 direct write with the soft bit
    wr(12'h10, 32'h4444_4444, "R7"); wr(12'h30, 32'h8000_00FF, "R7");
    rd(12'h30, "R7");
    chk_ports("R7");
    // R9 read-only and unused words
    wr(12'h80, 32'hFFFF_FFFF, "R9"); wr(12'h60, 32'hFFFF_FFFF, "R9");
    wr(12'h44, 32'hFFFF_FFFF, "R9"); wr(12'h84, 32'hFFFF_FFFF, "R9");
    rd(12'h80, "R9"); rd(12'h60, "R9");
    chk_ports("R9");
    // R10 out of range and misaligned
    rd(12'h84, "R10"); rd(12'hFFC, "R10");
    wr(12'h02, 32'h5555_5555, "R10"); rd(12'h01, "R10"); rd(12'h00, "R10");
    chk_ports("R10");
    repeat (3) @(negedge clk);
    cmp("R10", "pending scoreboard items", 32'(sq_rd.size()), 32'h0);
    summary();
  end
endmodule